// File: doc/BRIEF.md
# UART Interrupt Combiner and Status Flags

This block keeps the two status words of a UART and folds them into one level-sensitive interrupt line. The transmit and receive paths raise and lower status bits through per-bit set and clear event vectors. Software acknowledges the sticky event bits by writing ones to a write-one-to-clear vector for each word. Three control words, held outside the block, select which status bits may raise the interrupt.

The interrupt is a purely combinational function of the registered status words and the control inputs. For most bits, the enable sits in the same bit position as the status bit it gates, so a plain AND applies the mask. Two enables are placed elsewhere: the transmit-FIFO-empty enable and the receive ageing enable. When a set event and a clear of either kind reach the same bit in the same cycle, the set wins. A received character also raises the wake flag on its own.

Top module: `uart_irq_status`

## Requirements
- R1: Reset is asynchronous and active low. After reset, status word A reads 0x0380 (bit 7 receiver-idle, bit 8 transmit-ready, bit 9 RTS-status). Status word B reads 0x2048 (bit 3 transmit-complete, bit 6 DCD-in, bit 13 TX-FIFO-empty). With all control words zero, irq_o is low.
- R2: A bit set in a set vector reads as one from the next clock edge. It then holds until it is cleared.
- R3: A write-one-to-clear on word A clears only these bits: 0 parity, 1 RTS-delta, 2 escape, 3 framing, 5 ageing, 6 DTR-delta, 10 IR-interrupt, 11 awake (mask 0x0C6F). All other bits keep their value.
- R4: A write-one-to-clear on word B clears only these bits: 1 overrun, 2 break, 4 RTS-edge, 5 DCD-delta, 7 wake, 8 IR-interrupt, 9 ring-delta, 10 autobaud-start, 11 idle, 12 DTR-edge, 14 autobaud-detect (mask 0x5FB6). All other bits keep their value.
- R5: A hardware clear vector clears any implemented bit of its word at the next edge.
- R6: When a set and a clear (hardware or software) hit the same bit in the same cycle, the bit ends up set.
- R7: Unimplemented bits always read zero. These are word A bits 15:12 and word B bit 15.
- R8: A pulse on rx_char_i sets word B bit 7 (wake) at the next edge.
- R9: Word A bit 4 (receive-ready) and bit 8 (transmit-ready) raise irq_o only when the same-numbered bits of ctl_a_i are set.
- R10: Word A bit 5 (ageing) raises irq_o only when ctl_b_i bit 3 is set.
- R11: Word B bit 13 (TX-FIFO-empty) raises irq_o only when ctl_a_i bit 6 is set.
- R12: Word B bits 0 (data-ready), 1 (overrun), 3 (transmit-complete) and 7 (wake) raise irq_o only when the same-numbered bits of ctl_c_i are set. No other control bit enables any source.
- R13: irq_o follows a change of a control input within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sa_set_i | input | W | Set events for word A |
| sa_clr_i | input | W | Hardware clear events for word A |
| sa_w1c_i | input | W | Software write-one-to-clear data for word A |
| sb_set_i | input | W | Set events for word B |
| sb_clr_i | input | W | Hardware clear events for word B |
| sb_w1c_i | input | W | Software write-one-to-clear data for word B |
| rx_char_i | input | 1 | One-cycle pulse per received character |
| ctl_a_i | input | W | Control word with ready enables and TX-empty enable |
| ctl_b_i | input | W | Control word with ageing enable |
| ctl_c_i | input | W | Control word with word B event enables |
| sa_o | output | W | Status word A read value |
| sb_o | output | W | Status word B read value |
| irq_o | output | 1 | Combined interrupt, level |

## Verification
Several properties are checked on every cycle. A set always wins over a clear. Bits outside the write-one-to-clear masks survive software writes. A hardware clear takes effect, and unimplemented bits stay zero. A character pulse raises wake, and the interrupt stays low while every control word is zero. Other behaviours appear only in the bench's scenarios. These are the exact reset image, the clear masks of each word, and which enable position gates which source. The remapped TX-empty and ageing enables are among them. The bench also shows that the interrupt reacts to a control change within the same cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  // status word A
  localparam int unsigned SA_PARITY    = 0;
  localparam int unsigned SA_RTS_DELTA = 1;
  localparam int unsigned SA_ESCAPE    = 2;
  localparam int unsigned SA_FRAMING   = 3;
  localparam int unsigned SA_RX_RDY    = 4;
  localparam int unsigned SA_AGEING    = 5;
  localparam int unsigned SA_DTR_DELTA = 6;
  localparam int unsigned SA_RX_IDLE   = 7;
  localparam int unsigned SA_TX_RDY    = 8;
  localparam int unsigned SA_RTS_STAT  = 9;
  localparam int unsigned SA_IR_INT    = 10;
  localparam int unsigned SA_AWAKE     = 11;
  // status word B
  localparam int unsigned SB_DATA_RDY  = 0;
  localparam int unsigned SB_OVERRUN   = 1;
  localparam int unsigned SB_BREAK     = 2;
  localparam int unsigned SB_TX_DONE   = 3;
  localparam int unsigned SB_RTS_EDGE  = 4;
  localparam int unsigned SB_DCD_DELTA = 5;
  localparam int unsigned SB_DCD_IN    = 6;
  localparam int unsigned SB_WAKE      = 7;
  localparam int unsigned SB_IR_INT    = 8;
  localparam int unsigned SB_RING_DLT  = 9;
  localparam int unsigned SB_AB_START  = 10;
  localparam int unsigned SB_IDLE      = 11;
  localparam int unsigned SB_DTR_EDGE  = 12;
  localparam int unsigned SB_TXFE      = 13;
  localparam int unsigned SB_AB_DET    = 14;
  // remapped enables
  localparam int unsigned CA_TXE_EN    = 6;
  localparam int unsigned CB_AGE_EN    = 3;

  function automatic logic [31:0] bm(input int unsigned p);
    return 32'd1 << p;
  endfunction

  localparam logic [31:0] SA_IMPL_M = bm(SA_PARITY) | bm(SA_RTS_DELTA) | bm(SA_ESCAPE) |
    bm(SA_FRAMING) | bm(SA_RX_RDY) | bm(SA_AGEING) | bm(SA_DTR_DELTA) | bm(SA_RX_IDLE) |
    bm(SA_TX_RDY) | bm(SA_RTS_STAT) | bm(SA_IR_INT) | bm(SA_AWAKE);
  localparam logic [31:0] SA_W1C_M = bm(SA_AWAKE) | bm(SA_IR_INT) | bm(SA_DTR_DELTA) |
    bm(SA_AGEING) | bm(SA_FRAMING) | bm(SA_ESCAPE) | bm(SA_RTS_DELTA) | bm(SA_PARITY);
  localparam logic [31:0] SA_RST_M = bm(SA_TX_RDY) | bm(SA_RX_IDLE) | bm(SA_RTS_STAT);
  localparam logic [31:0] SA_DIR_M = bm(SA_TX_RDY) | bm(SA_RX_RDY);

  localparam logic [31:0] SB_IMPL_M = bm(SB_DATA_RDY) | bm(SB_OVERRUN) | bm(SB_BREAK) |
    bm(SB_TX_DONE) | bm(SB_RTS_EDGE) | bm(SB_DCD_DELTA) | bm(SB_DCD_IN) | bm(SB_WAKE) |
    bm(SB_IR_INT) | bm(SB_RING_DLT) | bm(SB_AB_START) | bm(SB_IDLE) | bm(SB_DTR_EDGE) |
    bm(SB_TXFE) | bm(SB_AB_DET);
  localparam logic [31:0] SB_W1C_M = bm(SB_AB_DET) | bm(SB_DTR_EDGE) | bm(SB_IDLE) |
    bm(SB_AB_START) | bm(SB_RING_DLT) | bm(SB_IR_INT) | bm(SB_WAKE) | bm(SB_DCD_DELTA) |
    bm(SB_RTS_EDGE) | bm(SB_BREAK) | bm(SB_OVERRUN);
  localparam logic [31:0] SB_RST_M = bm(SB_TXFE) | bm(SB_TX_DONE) | bm(SB_DCD_IN);
  localparam logic [31:0] SB_DIR_M = bm(SB_TX_DONE) | bm(SB_OVERRUN) | bm(SB_DATA_RDY) |
    bm(SB_WAKE);
endpackage

// File: rtl/uart_irq_status_word.sv
module uart_irq_status_word #(
  parameter int unsigned     W        = 16,
  parameter logic [W-1:0]    RST_VAL  = '0,
  parameter logic [W-1:0]    W1C_MASK = '0,
  parameter logic [W-1:0]    IMPL     = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] w1c_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d, kill;

  // set has priority over both clear sources
  always_comb begin
    kill = clr_i | (w1c_i & W1C_MASK);
    q_d  = ((q_q & ~kill) | set_i) & IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL & IMPL;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/uart_irq_combine.sv
module uart_irq_combine #(
  parameter int unsigned  W       = 16,
  parameter logic [W-1:0] A_DIR   = '0,
  parameter logic [W-1:0] B_DIR   = '0,
  parameter int unsigned  A_AGE   = 5,
  parameter int unsigned  B_TXFE  = 13,
  parameter logic [W-1:0] AGE_EN  = '0,
  parameter logic [W-1:0] TXE_EN  = '0
) (
  input  logic [W-1:0] stat_a_i,
  input  logic [W-1:0] stat_b_i,
  input  logic [W-1:0] ctl_a_i,
  input  logic [W-1:0] ctl_b_i,
  input  logic [W-1:0] ctl_c_i,
  output logic         irq_o
);
  logic dir_a, dir_b, age_hit, txe_hit;

  always_comb begin
    dir_a   = |(stat_a_i & ctl_a_i & A_DIR);
    dir_b   = |(stat_b_i & ctl_c_i & B_DIR);
    age_hit = stat_a_i[A_AGE] & (|(ctl_b_i & AGE_EN));
    txe_hit = stat_b_i[B_TXFE] & (|(ctl_a_i & TXE_EN));
    irq_o   = dir_a | dir_b | age_hit | txe_hit;
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sa_set_i,
  input  logic [W-1:0] sa_clr_i,
  input  logic [W-1:0] sa_w1c_i,
  input  logic [W-1:0] sb_set_i,
  input  logic [W-1:0] sb_clr_i,
  input  logic [W-1:0] sb_w1c_i,
  input  logic         rx_char_i,
  input  logic [W-1:0] ctl_a_i,
  input  logic [W-1:0] ctl_b_i,
  input  logic [W-1:0] ctl_c_i,
  output logic [W-1:0] sa_o,
  output logic [W-1:0] sb_o,
  output logic         irq_o
);
  localparam logic [W-1:0] WAKE_M = W'(bm(SB_WAKE));

  logic [W-1:0] sb_set;
  assign sb_set = sb_set_i | (rx_char_i ? WAKE_M : '0);

  uart_irq_status_word #(
    .W(W), .RST_VAL(W'(SA_RST_M)), .W1C_MASK(W'(SA_W1C_M)), .IMPL(W'(SA_IMPL_M))
  ) u_word_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(sa_set_i), .clr_i(sa_clr_i),
    .w1c_i(sa_w1c_i), .q_o(sa_o)
  );

  uart_irq_status_word #(
    .W(W), .RST_VAL(W'(SB_RST_M)), .W1C_MASK(W'(SB_W1C_M)), .IMPL(W'(SB_IMPL_M))
  ) u_word_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(sb_set), .clr_i(sb_clr_i),
    .w1c_i(sb_w1c_i), .q_o(sb_o)
  );

  uart_irq_combine #(
    .W(W), .A_DIR(W'(SA_DIR_M)), .B_DIR(W'(SB_DIR_M)),
    .A_AGE(SA_AGEING), .B_TXFE(SB_TXFE),
    .AGE_EN(W'(bm(CB_AGE_EN))), .TXE_EN(W'(bm(CA_TXE_EN)))
  ) u_comb (
    .stat_a_i(sa_o), .stat_b_i(sb_o), .ctl_a_i(ctl_a_i), .ctl_b_i(ctl_b_i),
    .ctl_c_i(ctl_c_i), .irq_o(irq_o)
  );
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk
  import uart_irq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] sa_set_i,
  input logic [W-1:0] sa_clr_i,
  input logic [W-1:0] sa_w1c_i,
  input logic [W-1:0] sb_set_i,
  input logic [W-1:0] sb_clr_i,
  input logic [W-1:0] sb_w1c_i,
  input logic         rx_char_i,
  input logic [W-1:0] ctl_a_i,
  input logic [W-1:0] ctl_b_i,
  input logic [W-1:0] ctl_c_i,
  input logic [W-1:0] sa_o,
  input logic [W-1:0] sb_o,
  input logic         irq_o
);
  localparam logic [W-1:0] A_IMPL = W'(SA_IMPL_M);
  localparam logic [W-1:0] B_IMPL = W'(SB_IMPL_M);
  localparam logic [W-1:0] A_W1C  = W'(SA_W1C_M);
  localparam logic [W-1:0] B_W1C  = W'(SB_W1C_M);

  logic [W-1:0] keep_a, keep_b, set_a, set_b, drop_a;
  assign keep_a = sa_o & ~sa_clr_i & ~A_W1C;
  assign keep_b = sb_o & ~sb_clr_i & ~B_W1C;
  assign set_a  = sa_set_i & A_IMPL;
  assign set_b  = sb_set_i & B_IMPL;
  assign drop_a = sa_clr_i & ~sa_set_i;

  logic unused_w1c;
  assign unused_w1c = ^{sa_w1c_i, sb_w1c_i};

  a_r3_keep_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sa_o & $past(keep_a)) == $past(keep_a)));
  a_r4_keep_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sb_o & $past(keep_b)) == $past(keep_b)));
  a_r6_set_wins_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sa_o & $past(set_a)) == $past(set_a)));
  a_r6_set_wins_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sb_o & $past(set_b)) == $past(set_b)));
  a_r5_hw_clear_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sa_o & $past(drop_a)) == '0));
  a_r7_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sa_o & ~A_IMPL) == '0) && ((sb_o & ~B_IMPL) == '0));
  a_r8_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_char_i |=> sb_o[SB_WAKE]);
  a_r12_no_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_a_i == '0 && ctl_b_i == '0 && ctl_c_i == '0) |-> !irq_o);
endmodule

bind uart_irq_status uart_irq_status_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .sa_set_i(sa_set_i), .sa_clr_i(sa_clr_i), .sa_w1c_i(sa_w1c_i),
  .sb_set_i(sb_set_i), .sb_clr_i(sb_clr_i), .sb_w1c_i(sb_w1c_i),
  .rx_char_i(rx_char_i), .ctl_a_i(ctl_a_i), .ctl_b_i(ctl_b_i), .ctl_c_i(ctl_c_i),
  .sa_o(sa_o), .sb_o(sb_o), .irq_o(irq_o)
);

// File: tb/tb_uart_irq_status.sv
module tb_uart_irq_status;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [15:0] sa_set = '0, sa_clr = '0, sa_w1c = '0;
  logic [15:0] sb_set = '0, sb_clr = '0, sb_w1c = '0;
  logic rx_char = 1'b0;
  logic [15:0] ctl_a = '0, ctl_b = '0, ctl_c = '0;
  logic [15:0] sa_o, sb_o;
  logic irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_status #(.W(16)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .sa_set_i(sa_set), .sa_clr_i(sa_clr), .sa_w1c_i(sa_w1c),
    .sb_set_i(sb_set), .sb_clr_i(sb_clr), .sb_w1c_i(sb_w1c),
    .rx_char_i(rx_char), .ctl_a_i(ctl_a), .ctl_b_i(ctl_b), .ctl_c_i(ctl_c),
    .sa_o(sa_o), .sb_o(sb_o), .irq_o(irq_o)
  );

  typedef struct {
    string       tag;
    logic [15:0] a;
    logic [15:0] b;
    logic        irq;
  } item_t;

  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  logic [15:0] m_a, m_b;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic model_irq();
    return ((m_a & ctl_a & 16'h0110) != 0) || (m_a[5] && ctl_b[3]) ||
           (m_b[13] && ctl_a[6]) || ((m_b & ctl_c & 16'h008B) != 0);
  endfunction

  // driver: one clocked step, expected result queued for the monitor
  task automatic step(input string tag,
                      input logic [15:0] as, input logic [15:0] ac, input logic [15:0] aw,
                      input logic [15:0] bs, input logic [15:0] bc, input logic [15:0] bw,
                      input logic rx);
    item_t it;
    @(negedge clk);
    sa_set = as; sa_clr = ac; sa_w1c = aw;
    sb_set = bs; sb_clr = bc; sb_w1c = bw; rx_char = rx;
    @(posedge clk);
    #1;
    m_a = ((m_a & ~(ac | (aw & 16'h0C6F))) | as) & 16'h0FFF;
    m_b = ((m_b & ~(bc | (bw & 16'h5FB6))) | bs | (rx ? 16'h0080 : 16'h0000)) & 16'h7FFF;
    sa_set = '0; sa_clr = '0; sa_w1c = '0;
    sb_set = '0; sb_clr = '0; sb_w1c = '0; rx_char = 1'b0;
    it.tag = tag; it.a = m_a; it.b = m_b; it.irq = model_irq();
    q.push_back(it);
  endtask

  // control change, irq checked inside the same cycle (R13)
  task automatic set_ctl(input string tag, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] c);
    @(negedge clk);
    ctl_a = a; ctl_b = b; ctl_c = c;
    #1;
    chk({tag, " R13 irq"}, {15'd0, irq_o}, {15'd0, model_irq()});
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (q.size() != 0) begin
        it = q.pop_front();
        chk({it.tag, " word A"}, sa_o, it.a);
        chk({it.tag, " word B"}, sb_o, it.b);
        chk({it.tag, " irq"}, {15'd0, irq_o}, {15'd0, it.irq});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_a = 16'h0380;
    m_b = 16'h2048;
    #(CLK_PERIOD * 2 + 1);
    chk("R1 reset word A", sa_o, 16'h0380);
    chk("R1 reset word B", sb_o, 16'h2048);
    chk("R1 reset irq", {15'd0, irq_o}, 16'h0000);
    @(negedge clk);
    rst_ni = 1'b1;

    step("R2 R7 set all A", 16'hFFFF, '0, '0, '0, '0, '0, 1'b0);
    step("R3 w1c A", '0, '0, 16'hFFFF, '0, '0, '0, 1'b0);
    step("R5 hw clear A", '0, 16'hFFFF, '0, '0, '0, '0, 1'b0);
    step("R2 R7 set all B", '0, '0, '0, 16'hFFFF, '0, '0, 1'b0);
    step("R4 w1c B", '0, '0, '0, '0, '0, 16'hFFFF, 1'b0);
    step("R5 hw clear B", '0, '0, '0, '0, 16'hFFFF, '0, 1'b0);
    step("R6 set beats clear", 16'h0020, 16'h0020, 16'h0020, 16'h0002, 16'h0002, 16'h0002, 1'b0);
    step("R8 rx char wake", '0, 16'hFFFF, '0, '0, 16'hFFFF, '0, 1'b1);

    set_ctl("R12 other enables", '0, '0, 16'hFF74);
    set_ctl("R12 wake enable", '0, '0, 16'h0080);
    step("R12 clear B", '0, '0, '0, '0, 16'hFFFF, '0, 1'b0);
    step("R12 set rdy ovr done", '0, '0, '0, 16'h000B, '0, '0, 1'b0);
    set_ctl("R12 done enable", '0, '0, 16'h0008);
    set_ctl("R12 overrun enable", '0, '0, 16'h0002);
    set_ctl("R12 data-ready enable", '0, '0, 16'h0001);
    set_ctl("R12 break not enabled", '0, '0, 16'h0004);
    set_ctl("R12 all off", '0, '0, '0);

    step("R9 tx ready", 16'h0100, '0, '0, '0, 16'hFFFF, '0, 1'b0);
    set_ctl("R9 wrong enables", 16'hFEEF, '0, '0);
    set_ctl("R9 tx ready enable", 16'h0100, '0, '0);
    step("R9 rx ready", 16'h0010, 16'h0100, '0, '0, '0, '0, 1'b0);
    set_ctl("R9 rx ready enable", 16'h0010, '0, '0);

    set_ctl("R10 off", '0, '0, '0);
    step("R10 ageing", 16'h0020, 16'hFFFF, '0, '0, '0, '0, 1'b0);
    set_ctl("R10 wrong enables", '0, 16'hFFF7, '0);
    set_ctl("R10 ageing enable", '0, 16'h0008, '0);
    set_ctl("R10 same position no effect", 16'h0020, '0, '0);

    set_ctl("R11 off", '0, '0, '0);
    step("R11 tx fifo empty", '0, 16'hFFFF, '0, 16'h2000, '0, '0, 1'b0);
    set_ctl("R11 same position no effect", 16'h2000, '0, '0);
    set_ctl("R11 remapped enable", 16'h0040, '0, '0);

    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule